// File: doc/BRIEF.md
# Clock Source and Low-Power Controller

This block chooses where the CPU clock comes from and how fast it runs. There are two sources: an external main oscillator and an on-chip ring oscillator. The block works from a small configuration word that software writes: a 2-bit source/ratio select, a ring-run bit, a main-halt bit, a stop-detector-arming bit and a stop-lock bit. Together these fields place the block in one of six clocking states. A write is applied only when it follows one edge of that state graph and passes that edge's guard. Any other write leaves the configuration as it was and sets a sticky error flag.

The block produces a one-cycle CPU clock enable at the selected ratio of the base clock. It also drives an enable for each oscillator and reports status: the state number, the power mode and the error flag. Stop and wait requests move the block into a low-power mode, and an interrupt brings it back. Stop is refused under several conditions: when the ring oscillator drives the CPU, when a converter-busy input is high, when the stop lock is set, or when the stop detector is armed. The oscillator type, the main-oscillator-settled indication and the converter-busy indication arrive as plain input flags.

Top module: `clksrc_lp_ctrl`

## Requirements
- R1: After reset the block is in state 1 with select 01 (divide by 8). The power mode is run (st_mode 0), the error flag is low, main_osc_en is high and ring_osc_en is low.
- R2: In run mode, cpu_clk_en pulses once every 2 cycles for select 00, every 8 cycles for select 01 and every cycle for select 11. Select 10 picks the ring oscillator.
- R3: While the ring oscillator is the source (states 3, 4, 6), the ratio is forced to divide by 8.
- R4: The ring-run bit moves the block between state 1 (ring stopped) and state 2 (ring running). ring_osc_en follows this bit.
- R5: Select 10 is accepted only from state 2 with the ring running, which gives state 3. The main-halt bit moves between state 3 and state 4. main_osc_en is low in state 4.
- R6: Leaving a ring-sourced state for a main-sourced state (3 to 2, or 6 to 5) is accepted only while main_stable is high.
- R7: Select 11 is accepted only while ceramic is high.
- R8: The arm bit moves between 2 and 5 and between 3 and 6. State 5 is 2 armed, state 6 is 3 armed, and 5 and 6 are linked through select 10. Arming from state 1 or state 4 is rejected.
- R9: A write that changes more than one of {ring selected, ring-run, main-halt, arm} is rejected, and so is a write whose target is not one of the six states. A rejected write leaves everything unchanged and sets st_err, which stays high until reset.
- R10: A stop request moves run to stop (st_mode 2) only in a main-sourced state that is not armed, with adc_busy low and the stop lock clear. Otherwise it is ignored.
- R11: A wait request moves run to wait (st_mode 1). Wait holds cpu_clk_en low and leaves both oscillator enables unchanged. Stop holds cpu_clk_en and both oscillator enables low.
- R12: irq returns wait or stop to run. Writes made outside run mode are ignored and set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Source/ratio select |
| wr_ring_on | input | 1 | Ring oscillator run bit |
| wr_main_off | input | 1 | Main oscillator halt bit |
| wr_det_on | input | 1 | Stop-detector arm bit |
| wr_stop_lock | input | 1 | Stop request lock |
| ceramic | input | 1 | Main oscillator is a ceramic resonator |
| main_stable | input | 1 | Main oscillator has settled |
| adc_busy | input | 1 | Converter busy |
| stop_req | input | 1 | Stop request |
| wait_req | input | 1 | Wait request |
| irq | input | 1 | Interrupt, wakes from wait/stop |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| main_osc_en | output | 1 | Main oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| st_state | output | 3 | State number 1 to 6 |
| st_mode | output | 2 | 0 run, 1 wait, 2 stop |
| st_err | output | 1 | Sticky illegal-write flag |

## Verification
A write, request or interrupt sampled at a rising edge changes the state, mode, error and oscillator enables at that same edge. The divider count is cleared at that edge, so the first new-ratio pulse arrives one full period later. Reset release takes effect on the third rising edge after rst_n goes high. The bench drives on falling edges and compares every output to a behavioural model at each falling edge. Scripted checks count enable pulses over windows that are whole multiples of the expected period.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2
  } pm_mode_e;

  localparam logic [1:0] SEL_HALF   = 2'b00;
  localparam logic [1:0] SEL_EIGHTH = 2'b01;
  localparam logic [1:0] SEL_RING   = 2'b10;
  localparam logic [1:0] SEL_FULL   = 2'b11;

  typedef struct packed {
    logic [1:0] sel;
    logic       ring_on;
    logic       main_off;
    logic       det_on;
    logic       stop_lock;
  } clk_cfg_t;

endpackage

// File: rtl/clkpm_cfg.sv
module clkpm_cfg
  import clkpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_fire,
  input  clk_cfg_t wr_cfg,
  input  logic     main_stable,
  input  logic     ceramic,
  output clk_cfg_t cfg_q,
  output logic     wr_ok,
  output logic     err_q
);

  clk_cfg_t   cfg_d;
  logic       err_d;
  logic       tgt_ring, cur_ring, shape_ok, legal;
  logic [2:0] n_flip;

  always_comb begin
    tgt_ring = (wr_cfg.sel == SEL_RING);
    cur_ring = (cfg_q.sel == SEL_RING);
    shape_ok = (!tgt_ring && !wr_cfg.ring_on && !wr_cfg.main_off && !wr_cfg.det_on)
            || (!tgt_ring && wr_cfg.ring_on && !wr_cfg.main_off)
            || (tgt_ring && wr_cfg.ring_on && !(wr_cfg.main_off && wr_cfg.det_on));
    n_flip = 3'($countones({tgt_ring ^ cur_ring,
                            wr_cfg.ring_on ^ cfg_q.ring_on,
                            wr_cfg.main_off ^ cfg_q.main_off,
                            wr_cfg.det_on ^ cfg_q.det_on}));
    legal = shape_ok && (n_flip <= 3'd1)
         && (!(cur_ring && !tgt_ring) || main_stable)
         && ((wr_cfg.sel != SEL_FULL) || ceramic);
    wr_ok = wr_fire && legal;
    cfg_d = cfg_q;
    err_d = err_q;
    if (wr_fire) begin
      if (legal) cfg_d = wr_cfg;
      else       err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{sel: SEL_EIGHTH, ring_on: 1'b0, main_off: 1'b0, det_on: 1'b0, stop_lock: 1'b0};
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  AST_RING_SRC_NEEDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.sel == SEL_RING) |-> cfg_q.ring_on) else $error("ring source without ring"); // R5
  AST_MAIN_HALT_ON_RING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.main_off |-> (cfg_q.sel == SEL_RING)) else $error("main halted while sourcing"); // R5
  AST_ARMED_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.det_on |-> (cfg_q.ring_on && !cfg_q.main_off)) else $error("armed in bad state"); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q) else $error("error flag cleared"); // R9
  AST_BACK_TO_MAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_q.sel) == SEL_RING) && (cfg_q.sel != SEL_RING)) |-> $past(main_stable))
    else $error("returned to main before settle"); // R6
  AST_FULL_NEEDS_CERAMIC: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q.sel == SEL_FULL) && ($past(cfg_q.sel) != SEL_FULL)) |-> $past(ceramic))
    else $error("undivided mode without ceramic"); // R7

endmodule

// File: rtl/clkpm_lpm.sv
module clkpm_lpm
  import clkpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stop_req,
  input  logic     wait_req,
  input  logic     irq,
  input  logic     ring_src,
  input  logic     det_on,
  input  logic     stop_lock,
  input  logic     adc_busy,
  output pm_mode_e mode_q
);

  pm_mode_e mode_d;
  logic     stop_ok;

  always_comb begin
    stop_ok = stop_req && !ring_src && !adc_busy && !stop_lock && !det_on;
    mode_d  = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (stop_ok)       mode_d = MODE_STOP;
        else if (wait_req) mode_d = MODE_WAIT;
      end
      default: begin
        if (irq) mode_d = MODE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  AST_STOP_ENTRY_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_STOP) && ($past(mode_q) == MODE_RUN))
      |-> $past(stop_req && !ring_src && !adc_busy && !stop_lock && !det_on))
    else $error("stop entered while blocked"); // R10
  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_RUN) && ($past(mode_q) != MODE_RUN)) |-> $past(irq))
    else $error("woke without interrupt"); // R12

endmodule

// File: rtl/clkpm_div.sv
module clkpm_div
  import clkpm_pkg::*;
#(
  parameter int HI_DIV  = 2,
  parameter int MID_DIV = 8,
  parameter int DBL_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int MAXR  = (HI_DIV > MID_DIV) ? ((HI_DIV > DBL_DIV) ? HI_DIV : DBL_DIV)
                                            : ((MID_DIV > DBL_DIV) ? MID_DIV : DBL_DIV);
  localparam int CNT_W = (MAXR > 1) ? $clog2(MAXR) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    unique case (sel)
      SEL_HALF: last = CNT_W'(HI_DIV - 1);
      SEL_FULL: last = CNT_W'(DBL_DIV - 1);
      default:  last = CNT_W'(MID_DIV - 1);
    endcase
    tick = run && (cnt_q == last);
    if (restart || !run)    cnt_d = '0;
    else if (cnt_q >= last) cnt_d = '0;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAXR) else $error("divider count out of range"); // R2

endmodule

// File: rtl/clksrc_lp_ctrl.sv
module clksrc_lp_ctrl
  import clkpm_pkg::*;
#(
  parameter int HI_DIV  = 2,
  parameter int MID_DIV = 8,
  parameter int DBL_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       wr_ring_on,
  input  logic       wr_main_off,
  input  logic       wr_det_on,
  input  logic       wr_stop_lock,
  input  logic       ceramic,
  input  logic       main_stable,
  input  logic       adc_busy,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       irq,
  output logic       cpu_clk_en,
  output logic       main_osc_en,
  output logic       ring_osc_en,
  output logic [2:0] st_state,
  output logic [1:0] st_mode,
  output logic       st_err
);

  logic [1:0] rst_sync;
  logic       rst_s;
  clk_cfg_t   wr_cfg, cfg_q;
  logic       wr_fire, wr_ok, err_q, run, ring_src;
  pm_mode_e   mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign wr_cfg  = '{sel: wr_sel, ring_on: wr_ring_on, main_off: wr_main_off,
                     det_on: wr_det_on, stop_lock: wr_stop_lock};
  assign run      = (mode_q == MODE_RUN);
  assign wr_fire  = wr_en && run;
  assign ring_src = (cfg_q.sel == SEL_RING);

  clkpm_cfg u_cfg (
    .clk(clk), .rst_n(rst_s), .wr_fire(wr_fire), .wr_cfg(wr_cfg),
    .main_stable(main_stable), .ceramic(ceramic),
    .cfg_q(cfg_q), .wr_ok(wr_ok), .err_q(err_q)
  );

  clkpm_lpm u_lpm (
    .clk(clk), .rst_n(rst_s), .stop_req(stop_req), .wait_req(wait_req), .irq(irq),
    .ring_src(ring_src), .det_on(cfg_q.det_on), .stop_lock(cfg_q.stop_lock),
    .adc_busy(adc_busy), .mode_q(mode_q)
  );

  clkpm_div #(.HI_DIV(HI_DIV), .MID_DIV(MID_DIV), .DBL_DIV(DBL_DIV)) u_div (
    .clk(clk), .rst_n(rst_s), .run(run), .restart(wr_ok), .sel(cfg_q.sel), .tick(cpu_clk_en)
  );

  always_comb begin
    main_osc_en = !cfg_q.main_off && (mode_q != MODE_STOP);
    ring_osc_en = cfg_q.ring_on && (mode_q != MODE_STOP);
    st_mode     = mode_q;
    st_err      = err_q;
    if (!ring_src) begin
      if (!cfg_q.ring_on)    st_state = 3'd1;
      else if (cfg_q.det_on) st_state = 3'd5;
      else                   st_state = 3'd2;
    end else begin
      if (cfg_q.det_on)        st_state = 3'd6;
      else if (cfg_q.main_off) st_state = 3'd4;
      else                     st_state = 3'd3;
    end
  end

  AST_NO_CLK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q != MODE_RUN) |-> !cpu_clk_en) else $error("clock enable while idle"); // R11
  AST_OSC_OFF_IN_STOP: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q == MODE_STOP) |-> (!main_osc_en && !ring_osc_en)) else $error("oscillator on in stop"); // R11

endmodule

// File: tb/tb_clksrc_lp_ctrl.sv
module tb_clksrc_lp_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wr_en = 0, wr_ring_on = 0, wr_main_off = 0, wr_det_on = 0, wr_stop_lock = 0;
  logic [1:0] wr_sel = 2'b01;
  logic ceramic = 0, main_stable = 0, adc_busy = 0, stop_req = 0, wait_req = 0, irq = 0;
  logic cpu_clk_en, main_osc_en, ring_osc_en, st_err;
  logic [2:0] st_state;
  logic [1:0] st_mode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clksrc_lp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ring_on(wr_ring_on),
    .wr_main_off(wr_main_off), .wr_det_on(wr_det_on), .wr_stop_lock(wr_stop_lock),
    .ceramic(ceramic), .main_stable(main_stable), .adc_busy(adc_busy),
    .stop_req(stop_req), .wait_req(wait_req), .irq(irq),
    .cpu_clk_en(cpu_clk_en), .main_osc_en(main_osc_en), .ring_osc_en(ring_osc_en),
    .st_state(st_state), .st_mode(st_mode), .st_err(st_err)
  );

  // behavioural reference model
  int k = 0;
  int m_sel = 1, m_mode = 0, m_cnt = 0, m_cur = 1, m_tgt = 0, m_r = 8;
  bit m_ring = 0, m_moff = 0, m_det = 0, m_lock = 0, m_err = 0, m_ok = 0, m_acc = 0;

  function automatic int state_of(int sel, bit ring, bit moff, bit det);
    if (sel != 2) begin
      if (!ring && !moff && !det) return 1;
      if (ring && !moff && !det)  return 2;
      if (ring && !moff && det)   return 5;
      return 0;
    end
    if (ring && !moff && !det) return 3;
    if (ring && moff && !det)  return 4;
    if (ring && !moff && det)  return 6;
    return 0;
  endfunction

  function automatic int ratio_of(int sel);
    if (sel == 0) return 2;
    if (sel == 3) return 1;
    return 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) k = 0;
    else if (k < 3) k++;
    if (k < 3) begin
      m_sel = 1; m_ring = 0; m_moff = 0; m_det = 0; m_lock = 0; m_err = 0; m_mode = 0; m_cnt = 0;
    end else begin
      m_r   = ratio_of(m_sel);
      m_cur = state_of(m_sel, m_ring, m_moff, m_det);
      m_tgt = state_of(int'(wr_sel), wr_ring_on, wr_main_off, wr_det_on);
      case (m_cur * 10 + m_tgt)
        11, 22, 33, 44, 55, 66, 12, 21, 23, 34, 43, 25, 52, 56, 36, 63: m_ok = 1;
        32, 65: m_ok = main_stable;
        default: m_ok = 0;
      endcase
      if (wr_sel == 2'b11 && !ceramic) m_ok = 0;
      m_acc = wr_en && (m_mode == 0) && m_ok;
      if (m_acc || m_mode != 0) m_cnt = 0;
      else m_cnt = (m_cnt + 1) % m_r;
      if (wr_en && m_mode == 0) begin
        if (m_ok) begin
          m_sel = int'(wr_sel); m_ring = wr_ring_on; m_moff = wr_main_off;
          m_det = wr_det_on; m_lock = wr_stop_lock;
        end else m_err = 1;
      end
      if (m_mode == 0) begin
        if (stop_req && m_cur != 3 && m_cur != 4 && m_cur != 6 && !adc_busy && !m_lock && !m_det)
          m_mode = 2;
        else if (wait_req) m_mode = 1;
      end else if (irq) m_mode = 0;
    end
  end

  task automatic expect_eq(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      expect_eq(int'(cpu_clk_en), int'(m_mode == 0 && m_cnt == ratio_of(m_sel) - 1), "R2 model cpu_clk_en");
      expect_eq(int'(main_osc_en), int'(!m_moff && m_mode != 2), "R5 model main_osc_en");
      expect_eq(int'(ring_osc_en), int'(m_ring && m_mode != 2), "R4 model ring_osc_en");
      expect_eq(int'(st_state), state_of(m_sel, m_ring, m_moff, m_det), "R9 model st_state");
      expect_eq(int'(st_mode), m_mode, "R10 model st_mode");
      expect_eq(int'(st_err), int'(m_err), "R9 model st_err");
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic r, input logic m, input logic d, input logic l);
    wr_en = 1; wr_sel = s; wr_ring_on = r; wr_main_off = m; wr_det_on = d; wr_stop_lock = l;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) stop_req = 1; else if (which == 1) wait_req = 1; else irq = 1;
    @(negedge clk);
    stop_req = 0; wait_req = 0; irq = 0;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu_clk_en) c++;
    end
  endtask

  int cnt;

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_eq(int'(st_state), 1, "R1 state");
    expect_eq(int'(st_mode), 0, "R1 mode");
    expect_eq(int'(st_err), 0, "R1 err");
    expect_eq(int'(main_osc_en), 1, "R1 main_osc_en");
    expect_eq(int'(ring_osc_en), 0, "R1 ring_osc_en");
    count_en(16, cnt); expect_eq(cnt, 2, "R2 divide by 8");
    wr(2'b00, 0, 0, 0, 0);
    count_en(16, cnt); expect_eq(cnt, 8, "R2 divide by 2");
    wr(2'b11, 0, 0, 0, 0);
    expect_eq(int'(st_err), 1, "R7 undivided rejected without ceramic");
    count_en(16, cnt); expect_eq(cnt, 8, "R7 ratio kept");
    ceramic = 1;
    wr(2'b11, 0, 0, 0, 0);
    count_en(16, cnt); expect_eq(cnt, 16, "R2 undivided");
    wr(2'b11, 1, 0, 0, 0);
    expect_eq(int'(st_state), 2, "R4 ring started");
    expect_eq(int'(ring_osc_en), 1, "R4 ring_osc_en");
    wr(2'b10, 1, 0, 0, 0);
    expect_eq(int'(st_state), 3, "R5 ring source");
    count_en(16, cnt); expect_eq(cnt, 2, "R3 ring forced divide by 8");
    wr(2'b10, 1, 1, 0, 0);
    expect_eq(int'(st_state), 4, "R5 main halted");
    expect_eq(int'(main_osc_en), 0, "R5 main_osc_en low");
    wr(2'b00, 1, 0, 0, 0);
    expect_eq(int'(st_state), 4, "R9 double change rejected");
    wr(2'b10, 1, 0, 0, 0);
    expect_eq(int'(st_state), 3, "R5 main restarted");
    pulse(0);
    expect_eq(int'(st_mode), 0, "R10 stop ignored on ring source");
    wr(2'b00, 1, 0, 0, 0);
    expect_eq(int'(st_state), 3, "R6 return blocked before settle");
    main_stable = 1;
    wr(2'b00, 1, 0, 0, 0);
    expect_eq(int'(st_state), 2, "R6 return after settle");
    wr(2'b00, 1, 0, 1, 0);
    expect_eq(int'(st_state), 5, "R8 armed from 2");
    pulse(0);
    expect_eq(int'(st_mode), 0, "R10 stop ignored while armed");
    main_stable = 0;
    wr(2'b10, 1, 0, 1, 0);
    expect_eq(int'(st_state), 6, "R8 armed ring source");
    wr(2'b00, 1, 0, 1, 0);
    expect_eq(int'(st_state), 6, "R6 armed return blocked");
    main_stable = 1;
    wr(2'b10, 1, 0, 0, 0);
    expect_eq(int'(st_state), 3, "R8 disarmed to 3");
    wr(2'b00, 1, 0, 0, 0);
    expect_eq(int'(st_state), 2, "R6 back to 2");
    adc_busy = 1;
    pulse(0);
    expect_eq(int'(st_mode), 0, "R10 stop ignored while converter busy");
    adc_busy = 0;
    wr(2'b00, 1, 0, 0, 1);
    pulse(0);
    expect_eq(int'(st_mode), 0, "R10 stop ignored while locked");
    wr(2'b00, 1, 0, 0, 0);
    pulse(0);
    expect_eq(int'(st_mode), 2, "R10 stop accepted");
    expect_eq(int'(main_osc_en) + int'(ring_osc_en), 0, "R11 oscillators off in stop");
    count_en(10, cnt); expect_eq(cnt, 0, "R11 no clock in stop");
    wr(2'b00, 0, 0, 0, 0);
    expect_eq(int'(st_state), 2, "R12 write ignored in stop");
    pulse(2);
    expect_eq(int'(st_mode), 0, "R12 wake from stop");
    pulse(1);
    expect_eq(int'(st_mode), 1, "R11 wait entered");
    expect_eq(int'(main_osc_en) + int'(ring_osc_en), 2, "R11 oscillators kept in wait");
    count_en(10, cnt); expect_eq(cnt, 0, "R11 no clock in wait");
    pulse(2);
    expect_eq(int'(st_mode), 0, "R12 wake from wait");
    count_en(16, cnt); expect_eq(cnt, 8, "R2 clock resumes");
    wr(2'b00, 0, 0, 0, 0);
    expect_eq(int'(st_state), 1, "R4 ring stopped");
    expect_eq(int'(ring_osc_en), 0, "R4 ring_osc_en low");
    wr(2'b00, 0, 0, 1, 0);
    expect_eq(int'(st_state), 1, "R8 arm from 1 rejected");
    do_reset();
    expect_eq(int'(st_err), 0, "R1 err cleared by reset");
    wr(2'b10, 0, 0, 0, 0);
    expect_eq(int'(st_err), 1, "R9 invalid target flagged");
    wr(2'b00, 1, 0, 0, 0);
    expect_eq(int'(st_state), 2, "R9 later legal write applies");
    expect_eq(int'(st_err), 1, "R9 error sticky");
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule